// File: doc/BRIEF.md
# SPI Slave Data Engine

This block is the slave side of a four-wire serial peripheral link. An external master supplies the serial clock and an active-low select line. The engine shifts 8-bit words in and out, most significant bit first, in clock mode 0: the incoming bit is captured on the rising clock edge and the next outgoing bit is put on the line after the falling edge. The serial clock, select and data inputs are brought into the system clock domain through two-flop synchronizers, so the system clock must run at least four times faster than the serial clock.

Software works through a 32-bit control word, a one-entry transmit holding register and a one-entry receive holding register. The control word holds an enable bit, an underrun fill level, a 3-bit transfer-mode field, a 4-bit stored interval field and a half-duplex direction bit. In full-duplex mode the engine receives on a data-in pin and sends on a data-out pin at the same time. In half-duplex mode it uses one shared data line, with an output-enable, and the direction bit decides whether the slave talks or listens. If the master clocks a word while the transmit holding register is empty, the engine sends the fill level for every bit of that word.

A single state machine runs each word. It has four states. In IDLE the engine waits. It moves IDLE to LOAD when it is enabled, selected and set to a valid mode. It moves LOAD to SHIFT after one cycle, with the transmit shifter filled. It moves SHIFT to DONE on the eighth rising clock edge. It moves DONE to LOAD to start the next word. If the engine is disabled, deselected or set to a reserved mode, it returns from any state to IDLE.

Top module: `spi_slave_engine`

## Requirements
- R1: Out of reset `ctrl_q` reads 0x0000_0300, `tx_empty` is 1, and `rx_valid` and `rx_overrun` are 0.
- R2: With bit 31 = 1 and mode field [14:12] = 3'b000 (full duplex), a selected 8-bit transfer captures `mosi_i` MSB first into `rx_data`, sets `rx_valid`, and drives the loaded transmit word MSB first on `miso_o`, stable at each rising SCLK edge.
- R3: Writing `tx_data` with `tx_wr` clears `tx_empty`. `tx_empty` becomes 1 when that word is moved into the shifter at the start of a word.
- R4: If a word starts while the transmit holding register is empty, every bit sent equals control bit 28 (the fill level).
- R5: While control bit 31 is 0, the engine ignores the bus. It does not shift, `miso_o` and `sio_oe` stay 0, `rx_valid` does not rise, and a loaded transmit word is not consumed.
- R6: With mode 3'b100 (half duplex) and control bit 1 = 1 (slave talks), `sio_oe` is 1 while selected, the transmit word appears MSB first on `sio_o`, and nothing is received.
- R7: With mode 3'b100 and control bit 1 = 0 (slave listens), `sio_oe` stays 0, the word on `sio_i` is captured into `rx_data`, and the transmit holding register is not consumed.
- R8: Mode values other than 3'b000 and 3'b100 are reserved. No transfer takes place, no word is received and no transmit word is consumed.
- R9: A control write that changes the mode field empties both buffers: `tx_empty` goes to 1, and `rx_valid` and `rx_overrun` go to 0. A write that keeps the mode field does not.
- R10: If a word completes while `rx_valid` is still set and not being read, `rx_overrun` is set and stays set, and `rx_data` takes the new word.
- R11: Pulsing `rx_rd` clears `rx_valid`.
- R12: If select is deasserted in the middle of a word, that partial word is dropped. The next transfer starts with a fresh word.
- R13: With select held low, consecutive words transfer back to back, each taking the transmit word loaded for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in (full duplex) |
| miso_o | output | 1 | Serial data out (full duplex) |
| sio_i | input | 1 | Shared data line, input side (half duplex) |
| sio_o | output | 1 | Shared data line, output side (half duplex) |
| sio_oe | output | 1 | Output enable for the shared data line |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Current control word |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_data | input | 8 | Transmit word |
| tx_empty | output | 1 | Transmit holding register is empty |
| rx_rd | input | 1 | Receive word read strobe; clears rx_valid |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | An unread received word is held |
| rx_overrun | output | 1 | Sticky flag: a word overwrote an unread one |

## Verification
The assertions check the buffer and flag rules on every cycle. A mode-changing write always leaves both buffers empty. The overrun flag never drops except through a flush. `rx_valid` only falls after a read or a flush, and only rises when the engine is enabled and set to a valid mode. The shared-line output enable is never raised outside half-duplex talk mode. Only the bench scenarios can show that the serial bit order, the fill level, the half-duplex direction, the mid-word abort and the back-to-back words give the right data values, because those depend on whole sequences of serial clock edges.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } slv_state_e;

    localparam int          CTRL_W        = 32;
    localparam int          EN_BIT        = 31;
    localparam int          FILL_BIT      = 28;
    localparam int          MODE_LSB      = 12;
    localparam int          MODE_W        = 3;
    localparam int          HD_OUT_BIT    = 1;
    localparam logic [2:0]  MODE_FULL     = 3'b000;
    localparam logic [2:0]  MODE_HALF     = 3'b100;
    localparam logic [31:0] CTRL_RESET    = 32'h0000_0300;
    localparam logic [31:0] CTRL_WR_MASK  = 32'h9000_7F02;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int               W       = 1,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
    import spi_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q,
    output logic              enable,
    output logic              fill,
    output logic              mode_full,
    output logic              mode_half,
    output logic              hd_out,
    output logic              flush
);
    logic [MODE_W-1:0] cur_mode;
    logic [MODE_W-1:0] new_mode;

    assign cur_mode = q[MODE_LSB +: MODE_W];
    assign new_mode = wdata[MODE_LSB +: MODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTRL_RESET;
        end else if (we) begin
            q <= wdata & CTRL_WR_MASK;
        end
    end

    assign flush     = we && (new_mode != cur_mode);
    assign enable    = q[EN_BIT];
    assign fill      = q[FILL_BIT];
    assign hd_out    = q[HD_OUT_BIT];
    assign mode_full = (cur_mode == MODE_FULL);
    assign mode_half = (cur_mode == MODE_HALF);
endmodule

// File: rtl/spi_slv_fsm.sv
module spi_slv_fsm
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sclk_s,
    input  logic              din,
    input  logic              tx_take,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              fill,
    output logic              dout,
    output logic              load_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    slv_state_e        state, nxt;
    logic              sclk_d;
    logic              rise, fall;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] tx_sr, rx_sr;

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_LOAD;
                ST_LOAD:  nxt = ST_SHIFT;
                ST_SHIFT: if (rise && cnt == LAST_BIT) nxt = ST_DONE;
                ST_DONE:  nxt = ST_LOAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
        end else begin
            sclk_d <= sclk_s;
            unique case (state)
                ST_IDLE: cnt <= '0;
                ST_LOAD: begin
                    cnt   <= '0;
                    tx_sr <= (tx_take && tx_avail) ? tx_word : {WORD_W{fill}};
                end
                ST_SHIFT: begin
                    if (rise) begin
                        rx_sr <= {rx_sr[WORD_W-2:0], din};
                        cnt   <= cnt + 1'b1;
                    end else if (fall && cnt != '0) begin
                        tx_sr <= {tx_sr[WORD_W-2:0], fill};
                    end
                end
                ST_DONE: cnt <= '0;
            endcase
        end
    end

    assign dout    = tx_sr[WORD_W-1];
    assign load_o  = (state == ST_LOAD);
    assign done_o  = (state == ST_DONE);
    assign rx_word = rx_sr;
endmodule

// File: rtl/spi_slv_bufs.sv
module spi_slv_bufs #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_pop,
    output logic              tx_full,
    output logic [WORD_W-1:0] tx_hold,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_hold <= '0;
        end else if (flush) begin
            tx_full <= 1'b0;
        end else if (tx_wr) begin
            tx_full <= 1'b1;
            tx_hold <= tx_data;
        end else if (tx_pop) begin
            tx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else if (flush) begin
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else if (rx_push) begin
            rx_data  <= rx_word;
            rx_valid <= 1'b1;
            if (rx_valid && !rx_rd) begin
                rx_overrun <= 1'b1;
            end
        end else if (rx_rd) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              sio_i,
    output logic              sio_o,
    output logic              sio_oe,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    output logic [31:0]       ctrl_q,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_overrun
);
    logic              enable, fill, mode_full, mode_half, hd_out, flush;
    logic [3:0]        pins_s;
    logic              sclk_s, cs_act, mosi_s, sio_s;
    logic              active, tx_take, rx_take, din, dout;
    logic              load, done, tx_full;
    logic [WORD_W-1:0] tx_hold, rx_word;

    spi_slv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctrl_we),
        .wdata     (ctrl_wdata),
        .q         (ctrl_q),
        .enable    (enable),
        .fill      (fill),
        .mode_full (mode_full),
        .mode_half (mode_half),
        .hd_out    (hd_out),
        .flush     (flush)
    );

    spi_slv_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sio_i, mosi_i, cs_n_i, sclk_i}),
        .q     (pins_s)
    );

    assign sclk_s  = pins_s[0];
    assign cs_act  = ~pins_s[1];
    assign mosi_s  = pins_s[2];
    assign sio_s   = pins_s[3];

    assign active  = enable && cs_act && (mode_full || mode_half);
    assign tx_take = mode_full || (mode_half && hd_out);
    assign rx_take = mode_full || (mode_half && !hd_out);
    assign din     = mode_full ? mosi_s : sio_s;

    spi_slv_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .sclk_s   (sclk_s),
        .din      (din),
        .tx_take  (tx_take),
        .tx_avail (tx_full),
        .tx_word  (tx_hold),
        .fill     (fill),
        .dout     (dout),
        .load_o   (load),
        .done_o   (done),
        .rx_word  (rx_word)
    );

    spi_slv_bufs #(.WORD_W(WORD_W)) u_bufs (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .tx_pop     (load && tx_take),
        .tx_full    (tx_full),
        .tx_hold    (tx_hold),
        .rx_push    (done && rx_take),
        .rx_word    (rx_word),
        .rx_rd      (rx_rd),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_overrun (rx_overrun)
    );

    assign tx_empty = ~tx_full;
    assign miso_o   = (active && mode_full) ? dout : 1'b0;
    assign sio_oe   = active && mode_half && hd_out;
    assign sio_o    = sio_oe ? dout : 1'b0;
endmodule

// File: rtl/spi_slave_engine_chk.sv
module spi_slave_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        miso_o,
    input logic        sio_oe,
    input logic        ctrl_we,
    input logic [31:0] ctrl_wdata,
    input logic [31:0] ctrl_q,
    input logic        tx_wr,
    input logic        tx_empty,
    input logic        rx_rd,
    input logic        rx_valid,
    input logic        rx_overrun
);
    logic flush_w;
    logic mode_ok;
    assign flush_w = ctrl_we && (ctrl_wdata[14:12] != ctrl_q[14:12]);
    assign mode_ok = (ctrl_q[14:12] == 3'b000) || (ctrl_q[14:12] == 3'b100);

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |=> (tx_empty && !rx_valid && !rx_overrun)); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !flush_w) |=> rx_overrun); // R10
    AST_RX_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_valid) |-> ($past(rx_rd) || $past(flush_w))); // R11
    AST_TX_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !flush_w) |=> !tx_empty); // R3
    AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(ctrl_q[31])); // R5
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[31] |-> (!miso_o && !sio_oe)); // R5
    AST_PUSH_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(mode_ok)); // R8
    AST_OE_HALF_TALK: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> (ctrl_q[14:12] == 3'b100 && ctrl_q[1])); // R6
endmodule

bind spi_slave_engine spi_slave_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso_o     (miso_o),
    .sio_oe     (sio_oe),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_q     (ctrl_q),
    .tx_wr      (tx_wr),
    .tx_empty   (tx_empty),
    .rx_rd      (rx_rd),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
);

// File: tb/tb_spi_slave_engine.sv
module tb_spi_slave_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0, cs_n_i = 1'b1, mosi_i = 1'b0, sio_i = 1'b0;
    logic        miso_o, sio_o, sio_oe;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_q;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_empty;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_overrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam logic [31:0] C_EN   = 32'h8000_0300;
    localparam logic [31:0] C_FILL = 32'h1000_0000;
    localparam logic [31:0] C_HALF = 32'h0000_4000;
    localparam logic [31:0] C_RSV  = 32'h0000_2000;
    localparam logic [31:0] C_TALK = 32'h0000_0002;

    // {fill, load_tx, tx[7:0], mosi[7:0]}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b1, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'h01, 8'h80},
        {1'b1, 1'b1, 8'h7E, 8'hFF},
        {1'b0, 1'b0, 8'h00, 8'h55},
        {1'b1, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'hC3}
    };

    spi_slave_engine dut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctrl_write(input logic [31:0] v);
        ctrl_wdata = v; ctrl_we = 1'b1; ticks(1); ctrl_we = 1'b0;
    endtask

    task automatic tx_load(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; ticks(1); tx_wr = 1'b0;
    endtask

    task automatic rx_pop();
        rx_rd = 1'b1; ticks(1); rx_rd = 1'b0;
    endtask

    task automatic sel_on();
        cs_n_i = 1'b0; ticks(8);
    endtask

    task automatic sel_off();
        cs_n_i = 1'b1; ticks(8);
    endtask

    task automatic word(input logic [7:0] out_b, input int nbits,
                        output logic [7:0] miso_b, output logic [7:0] sio_b,
                        output logic oe_all);
        miso_b = '0; sio_b = '0; oe_all = 1'b1;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi_i = out_b[i]; sio_i = out_b[i];
            ticks(4);
            miso_b[i] = miso_o; sio_b[i] = sio_o; oe_all = oe_all & sio_oe;
            sclk_i = 1'b1;
            ticks(4);
            sclk_i = 1'b0;
        end
        ticks(4);
    endtask

    initial begin
        logic [7:0] mb, sb, m2, s2;
        logic       oe;
        ticks(3);
        rst_n = 1'b1;
        ticks(2);

        // R1 reset state
        chk("R1 ctrl", ctrl_q, 32'h0000_0300);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 overrun", rx_overrun, 0);

        // R5 disabled: bus ignored, tx not consumed
        tx_load(8'h5A);
        sel_on(); word(8'hF0, 8, mb, sb, oe); sel_off();
        chk("R5 miso quiet", mb, 8'h00);
        chk("R5 rx_valid", rx_valid, 0);
        chk("R5 tx kept", tx_empty, 0);

        // Vector table, full duplex: R2 R3 R4
        for (int v = 0; v < 6; v++) begin
            logic [7:0] exp_m;
            ctrl_write(C_EN | (VEC[v][17] ? C_FILL : 32'h0));
            if (v == 0) chk("R9 same mode no flush", tx_empty, 0);
            if (VEC[v][16] && v != 0) tx_load(VEC[v][15:8]);
            if (VEC[v][16]) chk("R3 loaded", tx_empty, 0);
            exp_m = VEC[v][16] ? VEC[v][15:8] : {8{VEC[v][17]}};
            if (v == 0) exp_m = 8'h5A;
            sel_on(); word(VEC[v][7:0], 8, mb, sb, oe); sel_off();
            chk(VEC[v][16] ? "R2 miso" : "R4 fill", mb, exp_m);
            chk("R2 rx_data", rx_data, VEC[v][7:0]);
            chk("R2 rx_valid", rx_valid, 1);
            chk("R3 emptied", tx_empty, 1);
            rx_pop();
            chk("R11 rx_rd clears", rx_valid, 0);
        end

        // R10 overrun, then R11
        tx_load(8'h11);
        sel_on(); word(8'h21, 8, mb, sb, oe); sel_off();
        sel_on(); word(8'h42, 8, mb, sb, oe); sel_off();
        chk("R10 overrun", rx_overrun, 1);
        chk("R10 new data", rx_data, 8'h42);
        rx_pop();
        chk("R11 cleared", rx_valid, 0);
        chk("R10 sticky", rx_overrun, 1);

        // R12 abort mid word
        sel_on(); word(8'hFF, 4, mb, sb, oe); sel_off();
        chk("R12 partial dropped", rx_valid, 0);
        sel_on(); word(8'h0F, 8, mb, sb, oe); sel_off();
        chk("R12 fresh word", rx_data, 8'h0F);
        rx_pop();

        // R13 back to back
        tx_load(8'hC9);
        sel_on();
        tx_load(8'h36);
        word(8'h81, 8, mb, sb, oe);
        chk("R13 rx first", rx_data, 8'h81);
        rx_pop();
        word(8'h18, 8, m2, s2, oe);
        sel_off();
        chk("R13 miso first", mb, 8'hC9);
        chk("R13 miso second", m2, 8'h36);
        chk("R13 rx second", rx_data, 8'h18);

        // R9 flush on mode change (rx_valid and overrun still set, tx loaded)
        tx_load(8'h77);
        chk("R9 pre tx", tx_empty, 0);
        ctrl_write(C_EN | C_HALF | C_TALK);
        chk("R9 tx flushed", tx_empty, 1);
        chk("R9 rx flushed", rx_valid, 0);
        chk("R9 overrun flushed", rx_overrun, 0);

        // R6 half duplex talk
        tx_load(8'hA6);
        sel_on(); word(8'hFF, 8, mb, sb, oe); sel_off();
        chk("R6 sio_o", sb, 8'hA6);
        chk("R6 sio_oe", oe, 1);
        chk("R6 no rx", rx_valid, 0);

        // R7 half duplex listen
        ctrl_write(C_EN | C_HALF);
        tx_load(8'h3C);
        sel_on(); word(8'h96, 8, mb, sb, oe); sel_off();
        chk("R7 rx_data", rx_data, 8'h96);
        chk("R7 sio_oe low", {31'b0, sio_oe} | {31'b0, sb != 8'h00}, 0);
        chk("R7 tx kept", tx_empty, 0);
        rx_pop();

        // R8 reserved mode
        ctrl_write(C_EN | C_RSV);
        tx_load(8'hE7);
        sel_on(); word(8'hBD, 8, mb, sb, oe); sel_off();
        chk("R8 no rx", rx_valid, 0);
        chk("R8 tx kept", tx_empty, 0);
        chk("R8 miso quiet", mb, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule